// File: doc/BRIEF.md
# Data Address Translator with Debug Bypass

This block translates data effective addresses from a load/store unit into physical addresses and memory attributes. It uses a small, fully associative data TLB whose entries come in on a flat port. Each request is looked up against every entry. The block returns one registered response: the physical address, the five storage attributes W, I, M, G and E, a permission verdict, and one-cycle strobes for a TLB miss and for a permission violation.

A debugger can switch translation off for data accesses while a debug session is active. It does this by setting a disable bit in the control word. In that mode the effective address passes straight through as the physical address, and the attributes come from five control-word bits. Every permission is granted and no TLB exception is raised. External bus errors are reported in every mode. The mode is sampled when a request is accepted, so changing the mode affects only later accesses.

Top module: `dxlate_unit`

## Requirements
- R1: Bypass applies only when `dbg_session_i` is 1 and `ctrl_i[16]` is 1. Otherwise the TLB translates and checks the access normally, and `bypass_o` reads 0 in the response.
- R2: In bypass, `pa_o` equals the request's effective address.
- R3: In bypass, `wimge_o[4:0]` equals {`ctrl_i[19]`, `ctrl_i[20]`, `ctrl_i[21]`, `ctrl_i[22]`, `ctrl_i[23]`}, which are the W, I, M, G and E bits in that order. The TLB entry's attributes are ignored.
- R4: In bypass, `perm_ok_o` is 1 for every combination of privilege and access type, including combinations whose TLB entry grants nothing.
- R5: In bypass, `miss_o` and `prot_o` stay 0 even when no TLB entry matches.
- R6: `bus_err_o` follows `ext_err_i` combinationally in every mode.
- R7: `ctrl_view_o` equals `ctrl_i`, except that reserved bits 17, 18 and 24 to 28 read as 0.
- R8: Entry i sits at `tlb_entries_i[i*50 +: 50]` with this layout:
  - [49]: valid
  - [48:29]: effective page number
  - [28:9]: real page number
  - [8:4]: W, I, M, G, E
  - [3:0]: SR, SW, UR, UW

  On a normal hit, `pa_o` is {real page number, `ea[11:0]`} and `wimge_o` comes from the entry. When several entries match, the lowest index wins.
- R9: On a normal miss, `miss_o` pulses for exactly one cycle together with the response. In that response `perm_ok_o`, `pa_o` and `wimge_o` read 0.
- R10: On a normal hit, the permission bit is selected by privilege and access type. The selection is UR for a user read, UW for a user write, SR for a supervisor read and SW for a supervisor write. `perm_ok_o` equals the selected bit. When the bit is 0, `prot_o` pulses for one cycle.
- R11: The response appears on the clock edge after a request with `req_valid_i` 1, flagged by `rsp_valid_o`. The mode, the control bits and the request are sampled at that edge, and later changes do not alter the response. After reset, all outputs driven by the response stage read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Data access request |
| req_ea_i | input | 32 | Effective address |
| req_write_i | input | 1 | 1 for a store, 0 for a load |
| req_user_i | input | 1 | 1 for user privilege, 0 for supervisor |
| dbg_session_i | input | 1 | Debug session active |
| ctrl_i | input | 32 | Debug control word |
| tlb_entries_i | input | NUM_ENT*50 | Flattened TLB entries |
| ext_err_i | input | 1 | External access error from the bus |
| ctrl_view_o | output | 32 | Control word with reserved bits cleared |
| rsp_valid_o | output | 1 | Response valid |
| pa_o | output | 32 | Physical address |
| wimge_o | output | 5 | Attributes W, I, M, G, E |
| perm_ok_o | output | 1 | Access permitted |
| miss_o | output | 1 | TLB miss strobe |
| prot_o | output | 1 | Permission violation strobe |
| bypass_o | output | 1 | Response was produced in bypass |
| bus_err_o | output | 1 | External error passthrough |

## Verification
The bench targets the following corner cases, each tied to the fault it would expose:
- The disable bit set outside a debug session: a design that ignores the session flag would pass the address through untranslated.
- Bypass against an empty TLB, and against entries that deny every permission: a design that lets the TLB leak through would raise a miss or a protection strobe there.
- Bypass with attribute patterns whose bit order is lopsided: a swapped W/E mapping shows up as a wrong attribute word.
- Two matching entries: a wrong lookup priority returns the higher entry's page.
- All four privilege and direction combinations: a crossed permission select grants or denies the wrong access.
- Changing the mode and the control word right after a request is accepted: a response that is not sampled at acceptance changes under the consumer.

// File: rtl/dxl_pkg.sv
package dxl_pkg;
  localparam int EA_W     = 32;
  localparam int OFF_W    = 12;
  localparam int PN_W     = EA_W - OFF_W;
  localparam int CTRL_W   = 32;
  localparam int CB_DOFF  = 16;
  localparam int CB_W     = 19;
  localparam int CB_I     = 20;
  localparam int CB_M     = 21;
  localparam int CB_G     = 22;
  localparam int CB_E     = 23;
  localparam logic [CTRL_W-1:0] CTRL_RSVD = 32'h1F06_0000;

  typedef struct packed {
    logic            valid;
    logic [PN_W-1:0] epn;
    logic [PN_W-1:0] rpn;
    logic [4:0]      wimge;
    logic            sr;
    logic            sw;
    logic            ur;
    logic            uw;
  } tlb_ent_t;

  localparam int ENT_W = $bits(tlb_ent_t);

  typedef struct packed {
    logic [EA_W-1:0] pa;
    logic [4:0]      wimge;
    logic            perm_ok;
    logic            miss;
    logic            prot;
    logic            bypass;
  } xl_res_t;
endpackage

// File: rtl/dxl_lookup.sv
module dxl_lookup
  import dxl_pkg::*;
#(
  parameter int NUM_ENT = 8
) (
  input  logic [PN_W-1:0] epn_i,
  input  tlb_ent_t        ents_i [NUM_ENT],
  output logic            hit_o,
  output tlb_ent_t        hit_ent_o
);
  logic [NUM_ENT-1:0] match;

  for (genvar gi = 0; gi < NUM_ENT; gi++) begin : g_cmp
    assign match[gi] = ents_i[gi].valid && (ents_i[gi].epn == epn_i);
  end

  // lowest index wins
  always_comb begin
    hit_o     = 1'b0;
    hit_ent_o = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o     = 1'b1;
        hit_ent_o = ents_i[i];
      end
    end
  end
endmodule

// File: rtl/dxl_perm.sv
module dxl_perm
  import dxl_pkg::*;
(
  input  tlb_ent_t ent_i,
  input  logic     write_i,
  input  logic     user_i,
  output logic     allow_o
);
  always_comb begin
    unique case ({user_i, write_i})
      2'b00:   allow_o = ent_i.sr;
      2'b01:   allow_o = ent_i.sw;
      2'b10:   allow_o = ent_i.ur;
      default: allow_o = ent_i.uw;
    endcase
  end
endmodule

// File: rtl/dxl_resp.sv
module dxl_resp
  import dxl_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic            bypass_i,
  input  logic [EA_W-1:0] ea_i,
  input  logic [4:0]      attr_i,
  input  logic            hit_i,
  input  tlb_ent_t        hit_ent_i,
  input  logic            allow_i,
  output logic            rsp_valid_o,
  output xl_res_t         res_o
);
  xl_res_t nxt;

  always_comb begin
    nxt = '0;
    if (bypass_i) begin
      nxt.pa      = ea_i;
      nxt.wimge   = attr_i;
      nxt.perm_ok = 1'b1;
      nxt.bypass  = 1'b1;
    end else if (hit_i) begin
      nxt.pa      = {hit_ent_i.rpn, ea_i[OFF_W-1:0]};
      nxt.wimge   = hit_ent_i.wimge;
      nxt.perm_ok = allow_i;
      nxt.prot    = !allow_i;
    end else begin
      nxt.miss    = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      res_o       <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        res_o <= nxt;
      end else begin
        res_o.miss <= 1'b0;
        res_o.prot <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dxlate_unit.sv
module dxlate_unit
  import dxl_pkg::*;
#(
  parameter int NUM_ENT = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  input  logic [EA_W-1:0]          req_ea_i,
  input  logic                     req_write_i,
  input  logic                     req_user_i,
  input  logic                     dbg_session_i,
  input  logic [CTRL_W-1:0]        ctrl_i,
  input  logic [NUM_ENT*ENT_W-1:0] tlb_entries_i,
  input  logic                     ext_err_i,
  output logic [CTRL_W-1:0]        ctrl_view_o,
  output logic                     rsp_valid_o,
  output logic [EA_W-1:0]          pa_o,
  output logic [4:0]               wimge_o,
  output logic                     perm_ok_o,
  output logic                     miss_o,
  output logic                     prot_o,
  output logic                     bypass_o,
  output logic                     bus_err_o
);
  tlb_ent_t ents [NUM_ENT];
  tlb_ent_t hit_ent;
  logic     hit, allow, bypass;
  logic [4:0] attr;
  xl_res_t  res;

  for (genvar gi = 0; gi < NUM_ENT; gi++) begin : g_unpack
    assign ents[gi] = tlb_ent_t'(tlb_entries_i[gi*ENT_W +: ENT_W]);
  end

  assign bypass = dbg_session_i && ctrl_i[CB_DOFF];
  assign attr   = {ctrl_i[CB_W], ctrl_i[CB_I], ctrl_i[CB_M], ctrl_i[CB_G], ctrl_i[CB_E]};

  dxl_lookup #(.NUM_ENT(NUM_ENT)) i_lookup (
    .epn_i     (req_ea_i[EA_W-1:OFF_W]),
    .ents_i    (ents),
    .hit_o     (hit),
    .hit_ent_o (hit_ent)
  );

  dxl_perm i_perm (
    .ent_i   (hit_ent),
    .write_i (req_write_i),
    .user_i  (req_user_i),
    .allow_o (allow)
  );

  dxl_resp i_resp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .bypass_i    (bypass),
    .ea_i        (req_ea_i),
    .attr_i      (attr),
    .hit_i       (hit),
    .hit_ent_i   (hit_ent),
    .allow_i     (allow),
    .rsp_valid_o (rsp_valid_o),
    .res_o       (res)
  );

  assign pa_o        = res.pa;
  assign wimge_o     = res.wimge;
  assign perm_ok_o   = res.perm_ok;
  assign miss_o      = res.miss;
  assign prot_o      = res.prot;
  assign bypass_o    = res.bypass;
  assign ctrl_view_o = ctrl_i & ~CTRL_RSVD;
  assign bus_err_o   = ext_err_i;
endmodule

// File: rtl/dxl_checker.sv
module dxl_checker
  import dxl_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [EA_W-1:0]   req_ea_i,
  input logic              dbg_session_i,
  input logic [CTRL_W-1:0] ctrl_i,
  input logic [CTRL_W-1:0] ctrl_view_o,
  input logic              rsp_valid_o,
  input logic [EA_W-1:0]   pa_o,
  input logic              perm_ok_o,
  input logic              miss_o,
  input logic              prot_o,
  input logic              bypass_o
);
  assert_no_session_no_bypass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !dbg_session_i |=> !bypass_o);

  assert_bypass_identity_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && dbg_session_i && ctrl_i[CB_DOFF] |=> bypass_o && pa_o == $past(req_ea_i));

  assert_bypass_full_perm_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && bypass_o |-> perm_ok_o);

  assert_bypass_no_exc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_o |-> !miss_o && !prot_o);

  assert_rsvd_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_view_o & CTRL_RSVD) == '0);

  assert_miss_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({miss_o, prot_o}) <= 1);

  assert_strobe_timing_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o && !miss_o && !prot_o);

  assert_rsp_follows_req_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
endmodule

bind dxlate_unit dxl_checker i_chk (.*);

// File: tb/test_dxlate_unit.sv
`timescale 1ns/1ps
module test_dxlate_unit;
  localparam int N  = 8;
  localparam int EW = 50;

  logic clk_i = 0, rst_ni = 0;
  logic req_valid_i = 0, req_write_i = 0, req_user_i = 0, dbg_session_i = 0, ext_err_i = 0;
  logic [31:0] req_ea_i = '0, ctrl_i = '0;
  logic [N*EW-1:0] tlb_entries_i = '0;
  logic [31:0] ctrl_view_o, pa_o;
  logic [4:0] wimge_o;
  logic rsp_valid_o, perm_ok_o, miss_o, prot_o, bypass_o, bus_err_o;

  int total = 0, bad = 0;
  bit done = 0;

  logic        t_v [N];
  logic [19:0] t_epn [N], t_rpn [N];
  logic [4:0]  t_wimge [N];
  logic [3:0]  t_perm [N];  // {sr, sw, ur, uw}

  always #4 clk_i = ~clk_i;

  dxlate_unit #(.NUM_ENT(N)) i_dxlate_unit (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic pack_tlb();
    for (int i = 0; i < N; i++)
      tlb_entries_i[i*EW +: EW] = {t_v[i], t_epn[i], t_rpn[i], t_wimge[i], t_perm[i]};
  endtask

  task automatic clear_tlb();
    for (int i = 0; i < N; i++) begin
      t_v[i] = 0; t_epn[i] = '0; t_rpn[i] = '0; t_wimge[i] = '0; t_perm[i] = '0;
    end
    pack_tlb();
  endtask

  task automatic rand_tlb();
    for (int i = 0; i < N; i++) begin
      t_v[i]     = ($urandom % 8) != 0;
      t_epn[i]   = 20'($urandom);
      t_rpn[i]   = 20'($urandom);
      t_wimge[i] = 5'($urandom);
      t_perm[i]  = 4'($urandom);
    end
    pack_tlb();
  endtask

  task automatic model(input logic [31:0] ea, input logic wr, usr, dbg, input logic [31:0] ctl,
                       output logic [31:0] pa, output logic [4:0] wi,
                       output logic ok, ms, pr, by);
    int idx = -1;
    by = dbg && ctl[16];
    pa = '0; wi = '0; ok = 0; ms = 0; pr = 0;
    if (by) begin
      pa = ea; wi = {ctl[19], ctl[20], ctl[21], ctl[22], ctl[23]}; ok = 1;
    end else begin
      for (int i = N - 1; i >= 0; i--) if (t_v[i] && t_epn[i] == ea[31:12]) idx = i;
      if (idx < 0) ms = 1;
      else begin
        pa = {t_rpn[idx], ea[11:0]};
        wi = t_wimge[idx];
        case ({usr, wr})
          2'b00: ok = t_perm[idx][3];
          2'b01: ok = t_perm[idx][2];
          2'b10: ok = t_perm[idx][1];
          default: ok = t_perm[idx][0];
        endcase
        pr = !ok;
      end
    end
  endtask

  // called at a negedge; returns at a negedge
  task automatic access(input logic [31:0] ea, input logic wr, usr, dbg, input logic [31:0] ctl, input bit perturb);
    logic [31:0] e_pa; logic [4:0] e_wi; logic e_ok, e_ms, e_pr, e_by;
    model(ea, wr, usr, dbg, ctl, e_pa, e_wi, e_ok, e_ms, e_pr, e_by);
    req_valid_i = 1; req_ea_i = ea; req_write_i = wr; req_user_i = usr;
    dbg_session_i = dbg; ctrl_i = ctl;
    @(posedge clk_i); #2;
    req_valid_i = 0;
    if (perturb) begin
      dbg_session_i = ~dbg; ctrl_i = ~ctl; req_ea_i = ~ea; req_user_i = ~usr;
    end
    @(negedge clk_i);
    chk("R11", 32'(rsp_valid_o), 32'd1, "rsp_valid");
    chk("R1",  32'(bypass_o), 32'(e_by), "bypass");
    chk(e_by ? "R2" : "R8",  pa_o, e_pa, "pa");
    chk(e_by ? "R3" : "R8",  32'(wimge_o), 32'(e_wi), "wimge");
    chk(e_by ? "R4" : "R10", 32'(perm_ok_o), 32'(e_ok), "perm_ok");
    chk(e_by ? "R5" : "R9",  32'(miss_o), 32'(e_ms), "miss");
    chk(e_by ? "R5" : "R10", 32'(prot_o), 32'(e_pr), "prot");
    @(negedge clk_i);
    chk("R9", 32'({rsp_valid_o, miss_o, prot_o}), 32'd0, "strobes after idle");
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired: actual=running expected=done");
      finish_up();
    end
  end

  initial begin
    logic [31:0] ea, ctl;
    void'($urandom(32'd4242));
    clear_tlb();
    #3;
    chk("R11", 32'({rsp_valid_o, miss_o, prot_o, perm_ok_o, bypass_o, wimge_o}), 32'd0, "reset flags");
    chk("R11", pa_o, 32'd0, "reset pa");
    @(negedge clk_i); rst_ni = 1; @(negedge clk_i);

    // R7 reserved bits
    ctrl_i = 32'hFFFF_FFFF; #1;
    chk("R7", ctrl_view_o, 32'hE0F9_FFFF, "ctrl view ones");
    ctrl_i = 32'h1F06_0000; #1;
    chk("R7", ctrl_view_o, 32'h0, "ctrl view rsvd only");

    // R6 bus error in both modes
    dbg_session_i = 1; ctrl_i = 32'h0001_0000; ext_err_i = 1; #1;
    chk("R6", 32'(bus_err_o), 32'd1, "bus err bypass");
    dbg_session_i = 0; ext_err_i = 0; #1;
    chk("R6", 32'(bus_err_o), 32'd0, "bus err normal low");
    ext_err_i = 1; #1;
    chk("R6", 32'(bus_err_o), 32'd1, "bus err normal");
    ext_err_i = 0;
    @(negedge clk_i);

    // R5 bypass against empty TLB; R3 lopsided attribute patterns
    access(32'hDEAD_B123, 1, 1, 1, 32'h0089_0000, 0);
    access(32'h0000_0FFC, 0, 0, 1, 32'h0011_0000, 0);
    // R1 disable bit set but no session -> miss
    access(32'hDEAD_B123, 0, 1, 0, 32'h00F9_0000, 0);

    // R4 bypass over an entry granting nothing
    t_v[2] = 1; t_epn[2] = 20'hABCDE; t_rpn[2] = 20'h12345; t_wimge[2] = 5'b10101; t_perm[2] = 4'b0000;
    pack_tlb();
    for (int k = 0; k < 4; k++)
      access(32'hABCD_E010, k[0], k[1], 1, 32'h0041_0000, 0);
    // R10 each permission bit alone, all four access kinds
    for (int p = 0; p < 4; p++) begin
      t_perm[2] = 4'(1 << p); pack_tlb();
      for (int k = 0; k < 4; k++)
        access(32'hABCD_E7F0, k[0], k[1], 0, 32'h0001_0000, 0);
    end
    // R8 multi-hit: lowest index wins
    t_v[5] = 1; t_epn[5] = 20'hABCDE; t_rpn[5] = 20'h55555; t_wimge[5] = 5'b01010; t_perm[5] = 4'hF;
    t_v[1] = 1; t_epn[1] = 20'hABCDE; t_rpn[1] = 20'h77777; t_wimge[1] = 5'b00111; t_perm[1] = 4'hF;
    pack_tlb();
    access(32'hABCD_E004, 0, 0, 0, 32'h0, 0);
    // R11 perturb after acceptance, both modes
    access(32'hABCD_E008, 1, 0, 0, 32'h0001_0000, 1);
    access(32'hABCD_E008, 1, 0, 1, 32'h00A9_0000, 1);

    // random mix
    for (int n = 0; n < 400; n++) begin
      if (n % 50 == 0) rand_tlb();
      ea  = $urandom;
      if ($urandom % 4 != 0) begin
        int e = int'($urandom % N);
        ea[31:12] = t_epn[e];
      end
      ctl = $urandom;
      access(ea, 1'($urandom), 1'($urandom), 1'($urandom), ctl, 1'($urandom % 8 == 0));
    end

    done = 1;
    finish_up();
  end
endmodule